// File: doc/BRIEF.md
# Interlocked Handshake Read Link

This block joins a read requester to a small read-only storage responder over one shared set of address/data lines and three control strobes: a read request, an acknowledge and a data-ready. No step of a read relies on a timing assumption. Every strobe change by one side is first observed by the other side, through a multi-flop synchronizer, before that side makes its own next move. A complete read takes eight strobe edges. The acknowledge strobe serves the responder in the first half of the read and the requester in the second half.

A client hands the requester a read command, which is an address with a valid flag taken while `cmd_ready` is high. Later it receives the stored word together with a one-cycle `done` pulse. The responder holds a computed table of words and waits a configurable number of cycles of access time before it presents the data. The strobes and the shared lines are brought out as observation outputs, so the whole exchange can be followed at the ports.

Top module: `hs_read_link`

## Requirements
- R1: While reset is low and after it is released, the request, acknowledge and data-ready strobes are low, the shared lines read zero, `done` is low and `cmd_ready` is high.
- R2: An accepted command raises the request strobe at the accepting clock edge. While the request is high, the shared lines carry the address, zero-extended.
- R3: Within one read, the strobes change in exactly this order, one strobe per cycle: request rises, acknowledge rises, request falls, acknowledge falls, data-ready rises, acknowledge rises, data-ready falls, acknowledge falls.
- R4: While data-ready is high, the shared lines carry the stored word for the requested address. The word for address a is (37*a + 11) modulo 2^DW.
- R5: `done` is high for exactly one cycle, in the cycle in which the final acknowledge fall appears, and `done_data` then holds the stored word for the address of that read.
- R6: `cmd_ready` stays low from the accepting edge until the final acknowledge fall has passed the synchronizer. A command presented while `cmd_ready` is low has no effect: it starts no read and produces no `done`.
- R7: Data-ready rises max(ACC_DLY, SYNC_STAGES+1) cycles after the acknowledge fall. With the defaults this is 3 cycles.
- R8: At most one side drives the shared lines at a time. When neither the request nor data-ready is high, the lines read zero.
- R9: Each strobe edge that answers an edge of the other side comes at least SYNC_STAGES+1 cycles after that edge. This applies to every edge of R3 except the first and the data-ready rise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock shared by both state machines |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Read command present |
| cmd_addr | input | AW | Address of the read command |
| cmd_ready | output | 1 | Requester accepts a command this cycle |
| done | output | 1 | One-cycle completion pulse |
| done_data | output | DW | Word returned by the last read |
| line_rreq | output | 1 | Observed read-request strobe |
| line_ack | output | 1 | Observed acknowledge strobe (either side) |
| line_rdy | output | 1 | Observed data-ready strobe |
| line_bus | output | DW | Observed shared address/data lines |

## Verification
The read path is tried with a full ascending sweep of the address range, with repeated reads of one address, and with reads that alternate between the lowest and highest addresses. The sweep catches wrong table words and wrong address capture. The repeated and alternating reads separate stale data from fresh data and expose truncation at the edges of the range. A further pattern presents commands with a different address while a read is in flight, which shows whether a busy requester really ignores them. On every cycle the bench follows the strobe edges against the eight-step order, the spacing those edges must keep, and the contents of the shared lines in each phase.

// File: rtl/hs_pkg.sv
package hs_pkg;
  typedef enum logic [1:0] {RQ_IDLE, RQ_REQ, RQ_WAIT, RQ_ACK} rq_state_e;
  typedef enum logic [1:0] {RS_IDLE, RS_ACK, RS_ACCESS, RS_DRIVE} rs_state_e;

  // stored word for an address: 37*a + 11, truncated by the caller
  function automatic logic [31:0] store_word(input int unsigned a);
    return 32'(a * 37 + 11);
  endfunction
endpackage

// File: rtl/hs_sync.sv
module hs_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  always_ff @(posedge clk) begin
    if (!rst_n) chain <= '0;
    else        chain <= {chain[STAGES-2:0], d};
  end

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hs_requester.sv
module hs_requester
  import hs_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic          done,
  output logic [DW-1:0] done_data,
  input  logic          ack_line,
  input  logic          rdy_line,
  input  logic [DW-1:0] bus_in,
  output logic          rreq_o,
  output logic          ack_o,
  output logic          oe_o,
  output logic [DW-1:0] drive_o
);
  rq_state_e     st;
  logic          ack_s, rdy_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (.clk(clk), .rst_n(rst_n), .d(ack_line), .q(ack_s));
  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_rdy (.clk(clk), .rst_n(rst_n), .d(rdy_line), .q(rdy_s));

  // named events
  logic ev_accept, ev_seen_ack, ev_seen_rdy, ev_seen_rdy_low;
  assign cmd_ready       = (st == RQ_IDLE) && !ack_s && !rdy_s;
  assign ev_accept       = cmd_valid && cmd_ready;
  assign ev_seen_ack     = (st == RQ_REQ) && ack_s;
  assign ev_seen_rdy     = (st == RQ_WAIT) && rdy_s;
  assign ev_seen_rdy_low = (st == RQ_ACK) && !rdy_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RQ_IDLE;
      rreq_o <= 1'b0;
      ack_o  <= 1'b0;
      oe_o   <= 1'b0;
      done   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
    end else begin
      done <= 1'b0;
      unique case (st)
        RQ_IDLE: if (ev_accept) begin
          addr_q <= cmd_addr;
          rreq_o <= 1'b1;
          oe_o   <= 1'b1;
          st     <= RQ_REQ;
        end
        RQ_REQ: if (ev_seen_ack) begin
          rreq_o <= 1'b0;
          oe_o   <= 1'b0;
          st     <= RQ_WAIT;
        end
        RQ_WAIT: if (ev_seen_rdy) begin
          data_q <= bus_in;
          ack_o  <= 1'b1;
          st     <= RQ_ACK;
        end
        RQ_ACK: if (ev_seen_rdy_low) begin
          ack_o <= 1'b0;
          done  <= 1'b1;
          st    <= RQ_IDLE;
        end
        default: st <= RQ_IDLE;
      endcase
    end
  end

  assign drive_o   = DW'(addr_q);
  assign done_data = data_q;

  a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
    rreq_o && !ack_s |=> rreq_o);
  a_r3_ack_after_rdy: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(rdy_s));
  a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  a_r6_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_ready |-> !rreq_o && !ack_o && !oe_o);
endmodule

// File: rtl/hs_responder.sv
module hs_responder
  import hs_pkg::*;
#(
  parameter int DW = 16,
  parameter int AW = 4,
  parameter int DEPTH = 16,
  parameter int ACC_DLY = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          rreq_line,
  input  logic          ack_line,
  input  logic [DW-1:0] bus_in,
  output logic          ack_o,
  output logic          rdy_o,
  output logic          oe_o,
  output logic [DW-1:0] drive_o
);
  localparam int CW = (ACC_DLY > 1) ? $clog2(ACC_DLY) : 1;
  localparam int LAST = ACC_DLY - 1;

  rs_state_e     st;
  logic          rreq_s, ack_s;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] data_q;
  logic [CW-1:0] cnt;
  logic [DW-1:0] store [DEPTH];

  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_req (.clk(clk), .rst_n(rst_n), .d(rreq_line), .q(rreq_s));
  hs_sync #(.STAGES(SYNC_STAGES)) u_sync_ack (.clk(clk), .rst_n(rst_n), .d(ack_line),  .q(ack_s));

  for (genvar i = 0; i < DEPTH; i++) begin : g_store
    assign store[i] = DW'(store_word(i));
  end

  logic ev_take_addr, ev_req_gone, ev_access_end, ev_seen_ack;
  assign ev_take_addr  = (st == RS_IDLE) && rreq_s && !ack_s;
  assign ev_req_gone   = (st == RS_ACK) && !rreq_s;
  assign ev_access_end = (st == RS_ACCESS) && (int'(cnt) >= LAST) && !ack_s;
  assign ev_seen_ack   = (st == RS_DRIVE) && ack_s;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st     <= RS_IDLE;
      ack_o  <= 1'b0;
      rdy_o  <= 1'b0;
      oe_o   <= 1'b0;
      addr_q <= '0;
      data_q <= '0;
      cnt    <= '0;
    end else begin
      unique case (st)
        RS_IDLE: if (ev_take_addr) begin
          addr_q <= bus_in[AW-1:0];
          ack_o  <= 1'b1;
          st     <= RS_ACK;
        end
        RS_ACK: if (ev_req_gone) begin
          ack_o <= 1'b0;
          cnt   <= '0;
          st    <= RS_ACCESS;
        end
        RS_ACCESS: begin
          if (ev_access_end) begin
            data_q <= store[addr_q];
            rdy_o  <= 1'b1;
            oe_o   <= 1'b1;
            st     <= RS_DRIVE;
          end else if (int'(cnt) < LAST) begin
            cnt <= cnt + 1'b1;
          end
        end
        RS_DRIVE: if (ev_seen_ack) begin
          rdy_o <= 1'b0;
          oe_o  <= 1'b0;
          st    <= RS_IDLE;
        end
        default: st <= RS_IDLE;
      endcase
    end
  end

  assign drive_o = data_q;

  a_r3_ack_after_req: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ack_o) |-> $past(rreq_s));
  a_r3_rdy_drop_on_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(rdy_o) |-> $past(ack_s));
  a_r7_rdy_after_quiet_ack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_o) |-> $past(!ack_s) && !ack_o);
endmodule

// File: rtl/hs_read_link.sv
module hs_read_link #(
  parameter int DW = 16,
  parameter int DEPTH = 16,
  parameter int AW = $clog2(DEPTH),
  parameter int ACC_DLY = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [AW-1:0] cmd_addr,
  output logic          cmd_ready,
  output logic          done,
  output logic [DW-1:0] done_data,
  output logic          line_rreq,
  output logic          line_ack,
  output logic          line_rdy,
  output logic [DW-1:0] line_bus
);
  logic          rq_ack, rq_oe, rs_ack, rs_oe, rreq, rdy;
  logic [DW-1:0] rq_drive, rs_drive, bus;

  assign line_ack = rq_ack | rs_ack;
  assign bus = rq_oe ? rq_drive : (rs_oe ? rs_drive : '0);

  hs_requester #(.DW(DW), .AW(AW), .SYNC_STAGES(SYNC_STAGES)) u_req (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_ready(cmd_ready), .done(done), .done_data(done_data),
    .ack_line(line_ack), .rdy_line(rdy), .bus_in(bus),
    .rreq_o(rreq), .ack_o(rq_ack), .oe_o(rq_oe), .drive_o(rq_drive));

  hs_responder #(.DW(DW), .AW(AW), .DEPTH(DEPTH), .ACC_DLY(ACC_DLY),
                 .SYNC_STAGES(SYNC_STAGES)) u_rsp (
    .clk(clk), .rst_n(rst_n), .rreq_line(rreq), .ack_line(line_ack), .bus_in(bus),
    .ack_o(rs_ack), .rdy_o(rdy), .oe_o(rs_oe), .drive_o(rs_drive));

  assign line_rreq = rreq;
  assign line_rdy  = rdy;
  assign line_bus  = bus;

  a_r8_one_driver: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_oe && rs_oe));
  a_r3_ack_one_owner: assert property (@(posedge clk) disable iff (!rst_n)
    !(rq_ack && rs_ack));
endmodule

// File: tb/hs_read_link_tb.sv
module hs_read_link_tb;
  localparam int DW = 16, DEPTH = 16, AW = 4, ACC_DLY = 3, SYNC = 2;
  localparam int RDY_GAP = (ACC_DLY > SYNC + 1) ? ACC_DLY : SYNC + 1;

  logic clk = 0, rst_n = 0, cmd_valid = 0;
  logic [AW-1:0] cmd_addr = '0;
  logic cmd_ready, done, line_rreq, line_ack, line_rdy;
  logic [DW-1:0] done_data, line_bus;

  always #10 clk = ~clk;

  hs_read_link #(.DW(DW), .DEPTH(DEPTH), .ACC_DLY(ACC_DLY), .SYNC_STAGES(SYNC)) u_dut (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_addr(cmd_addr),
    .cmd_ready(cmd_ready), .done(done), .done_data(done_data),
    .line_rreq(line_rreq), .line_ack(line_ack), .line_rdy(line_rdy), .line_bus(line_bus));

  int checks = 0, errors = 0;
  logic [DW-1:0] q_addr[$], q_word[$];

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  function automatic logic [DW-1:0] word_of(input int a);
    int v;
    v = (a << 5) + (a << 2) + a + 11;
    return v[DW-1:0];
  endfunction

  task automatic issue(input int a, input bit poke);
    while (!cmd_ready) @(negedge clk);
    q_addr.push_back(DW'(a));
    q_word.push_back(word_of(a));
    cmd_valid = 1; cmd_addr = AW'(a);
    @(negedge clk);
    cmd_valid = 0;
    if (poke) begin
      for (int k = 0; k < 12; k++) begin
        if (!cmd_ready) begin
          cmd_valid = 1; cmd_addr = AW'(~a);
          @(negedge clk);
          cmd_valid = 0;
        end else @(negedge clk);
      end
    end
  endtask

  // scoreboard monitor
  int ev_line[8] = '{0, 1, 0, 1, 2, 1, 2, 1};
  bit ev_val[8]  = '{1, 1, 0, 0, 1, 1, 0, 0};
  int phase = 0, cyc = 0, last_cyc = 0, reads = 0;
  logic p_rreq = 0, p_ack = 0, p_rdy = 0;

  initial begin
    forever begin
      @(negedge clk);
      if (rst_n) begin
        int nchg, ln;
        bit val, fin;
        cyc++;
        fin = 0;
        nchg = int'(line_rreq != p_rreq) + int'(line_ack != p_ack) + int'(line_rdy != p_rdy);
        if (nchg > 1) chk(0, "R3 several strobes at once", 32'(nchg), 1);
        else if (nchg == 1) begin
          ln  = (line_rreq != p_rreq) ? 0 : ((line_ack != p_ack) ? 1 : 2);
          val = (ln == 0) ? line_rreq : ((ln == 1) ? line_ack : line_rdy);
          chk(ln == ev_line[phase] && val == ev_val[phase], "R3 edge order",
              32'(ln * 2 + int'(val)), 32'(ev_line[phase] * 2 + int'(ev_val[phase])));
          if (phase == 4) chk(cyc - last_cyc == RDY_GAP, "R7 access delay", 32'(cyc - last_cyc), 32'(RDY_GAP));
          else if (phase != 0) chk(cyc - last_cyc >= SYNC + 1, "R9 synchronized response", 32'(cyc - last_cyc), 32'(SYNC + 1));
          if (phase == 0) begin
            if (q_addr.size() == 0) chk(0, "R6 read with no command", 0, 1);
            else chk(line_bus == q_addr.pop_front(), "R2 address on lines", line_bus, 32'(cmd_addr));
          end
          if (phase == 7) fin = 1;
          phase = (phase + 1) % 8;
          last_cyc = cyc;
        end
        if (line_rdy) begin
          if (q_word.size() == 0) chk(0, "R4 data with no read", line_bus, 0);
          else chk(line_bus == q_word[0], "R4 data on lines", line_bus, q_word[0]);
        end
        if (!line_rreq && !line_rdy) chk(line_bus == '0, "R8 lines released", line_bus, 0);
        if (line_rreq || line_ack || line_rdy || phase != 0)
          chk(!cmd_ready, "R6 busy refuses commands", 32'(cmd_ready), 0);
        chk(done == fin, "R5 done timing", 32'(done), 32'(fin));
        if (done && fin && q_word.size() != 0) begin
          chk(done_data == q_word[0], "R5 done data", done_data, q_word[0]);
          void'(q_word.pop_front());
          reads++;
        end
        p_rreq = line_rreq; p_ack = line_ack; p_rdy = line_rdy;
      end
    end
  end

  initial begin
    int guard;
    fork
      begin
        repeat (3) @(negedge clk);
        chk(!line_rreq && !line_ack && !line_rdy, "R1 strobes low in reset",
            {29'd0, line_rreq, line_ack, line_rdy}, 0);
        chk(line_bus == '0 && !done, "R1 lines idle in reset", line_bus, 0);
        rst_n = 1;
        @(negedge clk);
        chk(cmd_ready, "R1 ready after reset", 32'(cmd_ready), 1);
        for (int a = 0; a < DEPTH; a++) issue(a, 0);
        for (int k = 0; k < 3; k++) issue(5, 0);
        for (int k = 0; k < 3; k++) begin issue(0, 0); issue(DEPTH - 1, 0); end
        issue(9, 1);
        issue(2, 1);
        guard = 0;
        while ((q_word.size() != 0 || phase != 0) && guard < 2000) begin
          @(negedge clk); guard++;
        end
        repeat (10) @(negedge clk);
        chk(reads == DEPTH + 11 && q_word.size() == 0 && q_addr.size() == 0,
            "R6 ignored commands add no reads", 32'(reads), 32'(DEPTH + 11));
      end
      begin
        repeat (100000) @(negedge clk);
        chk(0, "watchdog expired", 0, 1);
      end
    join_any
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule